// File: doc/BRIEF.md
# Memory-Mapped Watchdog Timer

A register-mapped watchdog for a simple 32-bit bus. Each access is a single-cycle, word-aligned read or write. Software programs a reload value and then sets the enable bit in the control register. The live count then runs down toward zero. By default it steps once per microsecond, using a divide-by-`PRESCALE` tick taken from the peripheral clock. When the slow-tick lock is off and control bit 4 is clear, it steps on every clock instead. Software keeps the timer from expiring by writing a fixed 16-bit key to the restart register. A write with any other value leaves the timer alone.

When the count steps from 1 to 0, the block sends a one-cycle reset request to a separate pulse-shaping block. The exception is when the memory-controller-in-reset input is high at that moment. In that case no request goes out and the whole control register is cleared, so the timer stops itself. The count then stays at zero until it is reloaded. A reload comes from the restart key or from a new enable.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the count (byte offset 0x00) and the reload value (0x04) both read 0x014FB180. The control register (0x0C) reads 0x00000010 when LOCK_SLOW_TICK=1, or 0 otherwise. The width register (0x18) reads 0x000000FF, the mask register (0x1C) reads 0, and `rst_req_o` is low.
- R2: Writes to 0x00 are ignored. 0x08 always reads 0. The width register keeps bits 19:0 of a write and the mask register keeps all 32 bits. Any other offset reads 0 and a write to it changes nothing.
- R3: A write to 0x08 whose bits 15:0 equal 0x4755 loads the count from the reload value and restarts the prescaler from zero. Bits 31:16 are ignored. Any other value has no effect.
- R4: A control write is stored with bits 11:8 forced to 0. When LOCK_SLOW_TICK=1 (the default), bit 4 is also forced to 1; otherwise bit 4 is stored as written.
- R5: A control write that takes bit 0 (enable) from 0 to 1 loads the count from the reload value and clears the prescaler. A control write that clears bit 0 freezes the count at its present value.
- R6: While enabled, a count with control bit 4 set first drops PRESCALE (24) clocks after the load, and then every PRESCALE clocks. With bit 4 clear, the count drops on every clock.
- R7: When the count steps from 1 to 0 and `mem_rst_i` is low, `rst_req_o` is high for exactly one cycle. That is the first cycle in which the count reads 0. The count then holds at 0.
- R8: When the count steps from 1 to 0 and `mem_rst_i` is high, no request is raised and the control register becomes 0. It is not sanitized, so it reads 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; 0 when not reading |
| mem_rst_i | input | 1 | Memory controller is held in reset |
| rst_req_o | output | 1 | One-cycle reset request to the pulse block |

## Verification
The hardest condition to produce is a restart that arrives part-way through a prescaler period. Only this shows whether the prescaler really starts over, because a stale phase would move the next decrement earlier by a few clocks. To reach it, the bench restarts the timer, waits part of a period, and restarts it again. It then reads the count one clock before and one clock after the point exactly PRESCALE clocks later. The self-disable on expiry depends on holding `mem_rst_i` high through a complete countdown. A second instance with the slow-tick lock turned off is the only way to reach per-clock counting.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Byte offsets of the implemented registers.
   localparam int unsigned OFF_COUNT  = 32'h00;
   localparam int unsigned OFF_RELOAD = 32'h04;
   localparam int unsigned OFF_KICK   = 32'h08;
   localparam int unsigned OFF_CTRL   = 32'h0C;
   localparam int unsigned OFF_WIDTH  = 32'h18;
   localparam int unsigned OFF_MASK   = 32'h1C;

   // Control bit positions used by the datapath.
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_SLOW = 4;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_COUNT,
      SEL_RELOAD,
      SEL_KICK,
      SEL_CTRL,
      SEL_WIDTH,
      SEL_MASK
   } reg_sel_e;

   function automatic reg_sel_e decode_word(input int unsigned idx);
      reg_sel_e s;
      s = SEL_NONE;
      if (idx == OFF_COUNT / 4)  s = SEL_COUNT;
      if (idx == OFF_RELOAD / 4) s = SEL_RELOAD;
      if (idx == OFF_KICK / 4)   s = SEL_KICK;
      if (idx == OFF_CTRL / 4)   s = SEL_CTRL;
      if (idx == OFF_WIDTH / 4)  s = SEL_WIDTH;
      if (idx == OFF_MASK / 4)   s = SEL_MASK;
      return s;
   endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PRESCALE = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic clr_i,
   output logic tick_o
);
   localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   logic [PW-1:0] pcnt_q;

   assign tick_o = run_i & ~clr_i & (pcnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)               pcnt_q <= '0;
      else if (clr_i || !run_i) pcnt_q <= '0;
      else if (pcnt_q == LAST)  pcnt_q <= '0;
      else                      pcnt_q <= pcnt_q + 1'b1;
   end

   // R6
   pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q <= LAST);

   // R6
   pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> pcnt_q == '0);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int          CNT_W   = 32,
   parameter logic [31:0] RST_VAL = 32'h014F_B180
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   assign count_o  = cnt_q;
   assign expire_o = step_i & ~load_i & (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)                       cnt_q <= RST_VAL[CNT_W-1:0];
      else if (load_i)                  cnt_q <= load_val_i;
      else if (step_i && cnt_q != '0)   cnt_q <= cnt_q - ONE;
   end

   // R7
   hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load_i) |=> cnt_q == '0);

   // R5
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !step_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
   parameter bit LOCK_SLOW_TICK = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_i,
   input  logic [31:0] wdata_i,
   input  logic        clear_i,
   output logic [31:0] ctrl_o,
   output logic        en_rise_o,
   output logic        en_fall_o
);
   localparam logic [31:0] KEEP_MASK = ~32'h0000_0F00;

   logic [31:0] force_bits;
   logic [31:0] clean;
   logic [31:0] ctrl_q;

   generate
      if (LOCK_SLOW_TICK) begin : g_lock
         assign force_bits = 32'(1) << wdt_pkg::CB_SLOW;
      end else begin : g_free
         assign force_bits = '0;
      end
   endgenerate

   assign clean     = (wdata_i & KEEP_MASK) | force_bits;
   assign ctrl_o    = ctrl_q;
   assign en_rise_o = wr_i &  clean[wdt_pkg::CB_EN] & ~ctrl_q[wdt_pkg::CB_EN];
   assign en_fall_o = wr_i & ~clean[wdt_pkg::CB_EN] &  ctrl_q[wdt_pkg::CB_EN];

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= force_bits;
      else if (wr_i)    ctrl_q <= clean;
      else if (clear_i) ctrl_q <= '0;
   end

   // R4
   ctrl_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ctrl_q[11:8] == 4'h0);

   // R4
   ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && LOCK_SLOW_TICK) |=> ctrl_q[wdt_pkg::CB_SLOW]);

   // R8
   ctrl_selfoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_i && !wr_i) |=> ctrl_q == '0);

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
   parameter int          ADDR_W         = 6,
   parameter int          CNT_W          = 32,
   parameter int          PRESCALE       = 24,
   parameter int          WIDTH_BITS     = 20,
   parameter logic [31:0] RELOAD_RST     = 32'h014F_B180,
   parameter logic [31:0] WIDTH_RST      = 32'h0000_00FF,
   parameter logic [15:0] KICK_KEY       = 16'h4755,
   parameter bit          LOCK_SLOW_TICK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              mem_rst_i,
   output logic              rst_req_o
);
   import wdt_pkg::*;

   generate
      if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
         $error("tick_watchdog: ADDR_W must lie in 5..16");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("tick_watchdog: CNT_W must lie in 2..32");
      end
      if (PRESCALE < 2) begin : g_bad_pre
         $error("tick_watchdog: PRESCALE must be at least 2");
      end
      if (WIDTH_BITS < 1 || WIDTH_BITS > 32) begin : g_bad_width
         $error("tick_watchdog: WIDTH_BITS must lie in 1..32");
      end
   endgenerate

   reg_sel_e             sel;
   logic                 wr_hit;
   logic                 rd_hit;
   logic [CNT_W-1:0]     reload_q;
   logic [WIDTH_BITS-1:0] width_q;
   logic [31:0]          mask_q;
   logic [31:0]          ctrl;
   logic                 en_rise;
   logic                 en_fall;
   logic                 key_hit;
   logic                 load;
   logic                 slow_tick;
   logic                 step;
   logic [CNT_W-1:0]     cnt;
   logic                 expire;
   logic                 req_q;
   logic                 unused_bits;

   assign sel         = decode_word(int'(bus_addr[ADDR_W-1:2]));
   assign wr_hit      = bus_sel &  bus_wr;
   assign rd_hit      = bus_sel & ~bus_wr;
   assign unused_bits = ^{bus_addr[1:0], en_fall};

   assign key_hit = wr_hit && sel == SEL_KICK && bus_wdata[15:0] == KICK_KEY;
   assign load    = key_hit | en_rise;

   // Plain storage registers.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= RELOAD_RST[CNT_W-1:0];
         width_q  <= WIDTH_RST[WIDTH_BITS-1:0];
         mask_q   <= '0;
      end else if (wr_hit) begin
         if (sel == SEL_RELOAD) reload_q <= bus_wdata[CNT_W-1:0];
         if (sel == SEL_WIDTH)  width_q  <= bus_wdata[WIDTH_BITS-1:0];
         if (sel == SEL_MASK)   mask_q   <= bus_wdata;
      end
   end

   wdt_ctrl_reg #(
      .LOCK_SLOW_TICK (LOCK_SLOW_TICK)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_hit && sel == SEL_CTRL),
      .wdata_i   (bus_wdata),
      .clear_i   (expire & mem_rst_i),
      .ctrl_o    (ctrl),
      .en_rise_o (en_rise),
      .en_fall_o (en_fall)
   );

   wdt_prescaler #(
      .PRESCALE (PRESCALE)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (ctrl[CB_EN]),
      .clr_i  (load),
      .tick_o (slow_tick)
   );

   assign step = ctrl[CB_EN] & (ctrl[CB_SLOW] ? slow_tick : 1'b1);

   wdt_countdown #(
      .CNT_W   (CNT_W),
      .RST_VAL (RELOAD_RST)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (reload_q),
      .step_i     (step),
      .count_o    (cnt),
      .expire_o   (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= expire & ~mem_rst_i;
   end
   assign rst_req_o = req_q;

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         unique case (sel)
            SEL_COUNT:  bus_rdata = 32'(cnt);
            SEL_RELOAD: bus_rdata = 32'(reload_q);
            SEL_CTRL:   bus_rdata = ctrl;
            SEL_WIDTH:  bus_rdata = 32'(width_q);
            SEL_MASK:   bus_rdata = mask_q;
            default:    bus_rdata = '0;
         endcase
      end
   end

   // R3
   restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |=> cnt == $past(reload_q));

   // R5
   en_rise_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise |=> cnt == $past(reload_q));

   // R7
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

   // R7
   pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> cnt == '0);

   // R8
   memrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && mem_rst_i) |=> !rst_req_o);

endmodule

// File: tb/tick_watchdog_bench.sv
module tick_watchdog_bench;
   localparam int P = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        tgt = 1'b0;
   logic        mem_rst = 1'b0;
   logic [31:0] rdata0, rdata1;
   logic        req0, req1;
   int          cyc = 0;
   int          checks = 0;
   int          fails = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tick_watchdog u_tick_watchdog (
      .clk (clk), .rst_n (rst_n),
      .bus_sel (bus_sel & ~tgt), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (rdata0),
      .mem_rst_i (mem_rst), .rst_req_o (req0)
   );

   tick_watchdog #(.LOCK_SLOW_TICK(1'b0)) u_fast (
      .clk (clk), .rst_n (rst_n),
      .bus_sel (bus_sel & tgt), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (rdata1),
      .mem_rst_i (1'b0), .rst_req_o (req1)
   );

   typedef struct {
      logic        tgt;
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   rd_item_t rd_q[$];
   int       pq0[$];
   int       pq1[$];

   task automatic note(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // Driver tasks: each starts and ends on a falling edge.
   task automatic wr(input logic t, input logic [5:0] a,
                     input logic [31:0] d, output int edge_cyc);
      tgt = t; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      edge_cyc = cyc + 1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic t, input logic [5:0] a,
                     input logic [31:0] exp, input string tag);
      rd_item_t it;
      it.tgt = t; it.exp = exp; it.tag = tag;
      rd_q.push_back(it);
      tgt = t; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops expected reads and expected pulses.
   always @(negedge clk) begin
      #5;
      if (rst_n) begin
         if (bus_sel && !bus_wr) begin
            rd_item_t it;
            logic [31:0] act;
            it  = rd_q.pop_front();
            act = it.tgt ? rdata1 : rdata0;
            note(act === it.exp, it.tag, act, it.exp);
         end
         if (req0) begin
            if (pq0.size() > 0 && pq0[0] == cyc) begin
               void'(pq0.pop_front());
               note(1'b1, "R7 pulse", 32'(cyc), 32'(cyc));
            end else begin
               note(1'b0, "R7/R8 unexpected pulse on default unit", 32'(cyc),
                    pq0.size() > 0 ? 32'(pq0[0]) : 32'hFFFF_FFFF);
            end
         end
         if (req1) begin
            if (pq1.size() > 0 && pq1[0] == cyc) begin
               void'(pq1.pop_front());
               note(1'b1, "R6 fast pulse", 32'(cyc), 32'(cyc));
            end else begin
               note(1'b0, "R7 unexpected pulse on fast unit", 32'(cyc),
                    pq1.size() > 0 ? 32'(pq1[0]) : 32'hFFFF_FFFF);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      note(1'b0, "watchdog expired", 32'(cyc), 32'd0);
      summary();
      $finish;
   end

   initial begin
      int e;
      int c0, c2;
      idle(3);
      rst_n = 1'b1;

      // R1 reset state
      note(req0 === 1'b0, "R1 rst_req_o low after reset", 32'(req0), 32'd0);
      rd(0, 6'h00, 32'h014F_B180, "R1 count reset");
      rd(0, 6'h04, 32'h014F_B180, "R1 reload reset");
      rd(0, 6'h0C, 32'h0000_0010, "R1 control reset");
      rd(0, 6'h18, 32'h0000_00FF, "R1 width reset");
      rd(0, 6'h1C, 32'h0000_0000, "R1 mask reset");
      rd(1, 6'h0C, 32'h0000_0000, "R1 control reset unlocked unit");

      // R2 map behaviour
      wr(0, 6'h00, 32'h0000_0005, e);
      rd(0, 6'h00, 32'h014F_B180, "R2 count ignores writes");
      rd(0, 6'h08, 32'h0000_0000, "R2 restart reads zero");
      wr(0, 6'h10, 32'hFFFF_FFFF, e);
      rd(0, 6'h10, 32'h0000_0000, "R2 unmapped reads zero");
      wr(0, 6'h30, 32'h0000_4755, e);
      rd(0, 6'h00, 32'h014F_B180, "R2 unmapped write has no effect");
      wr(0, 6'h18, 32'hFFFF_FFFF, e);
      rd(0, 6'h18, 32'h000F_FFFF, "R2 width keeps 20 bits");
      wr(0, 6'h1C, 32'hDEAD_BEEF, e);
      rd(0, 6'h1C, 32'hDEAD_BEEF, "R2 mask keeps 32 bits");

      // R4 sanitizing, enable stays clear
      wr(0, 6'h0C, 32'h0000_0FFE, e);
      rd(0, 6'h0C, 32'h0000_00FE, "R4 control sanitized");
      rd(0, 6'h00, 32'h014F_B180, "R5 no load without enable");
      wr(0, 6'h0C, 32'h0000_0000, e);
      rd(0, 6'h0C, 32'h0000_0010, "R4 slow bit forced");

      // R5/R6/R7 slow countdown
      wr(0, 6'h04, 32'd3, e);
      wr(0, 6'h0C, 32'h0000_0011, c0);
      pq0.push_back(c0 + 3 * P);
      rd(0, 6'h00, 32'd3, "R5 enable loads count");
      idle(22);
      rd(0, 6'h00, 32'd3, "R6 no step before prescale period");
      rd(0, 6'h00, 32'd2, "R6 step after prescale period");
      idle(55);
      rd(0, 6'h00, 32'd0, "R7 count holds zero");
      rd(0, 6'h0C, 32'h0000_0011, "R7 control kept on expiry");

      // R3 restart key
      wr(0, 6'h08, 32'h0000_4756, e);
      rd(0, 6'h00, 32'd0, "R3 wrong key ignored");
      idle(30);
      wr(0, 6'h08, 32'hABCD_4755, e);
      idle(29);
      wr(0, 6'h08, 32'h0000_4755, c2);
      pq0.push_back(c2 + 3 * P);
      rd(0, 6'h00, 32'd3, "R3 key reloads count");
      idle(22);
      rd(0, 6'h00, 32'd3, "R3 prescaler cleared by restart");
      rd(0, 6'h00, 32'd2, "R3 first step one period after restart");
      idle(60);

      // R5 disable freezes
      wr(0, 6'h08, 32'h0000_4755, e);
      idle(29);
      wr(0, 6'h0C, 32'h0000_0010, e);
      rd(0, 6'h00, 32'd2, "R5 disable keeps count");
      idle(100);
      rd(0, 6'h00, 32'd2, "R5 count frozen while disabled");
      rd(0, 6'h0C, 32'h0000_0010, "R4 control after disable");
      wr(0, 6'h08, 32'h0000_4755, e);
      idle(50);
      rd(0, 6'h00, 32'd3, "R3 key loads while disabled, no run");

      // R8 memory reset suppresses expiry
      mem_rst = 1'b1;
      wr(0, 6'h04, 32'd2, e);
      wr(0, 6'h0C, 32'h0000_0011, e);
      idle(60);
      rd(0, 6'h0C, 32'h0000_0000, "R8 control cleared");
      rd(0, 6'h00, 32'd0, "R8 count at zero");
      mem_rst = 1'b0;
      idle(30);
      rd(0, 6'h00, 32'd0, "R8 stays stopped");

      // R6 per-clock counting on unlocked unit
      wr(1, 6'h04, 32'd5, e);
      wr(1, 6'h0C, 32'h0000_0001, c0);
      pq1.push_back(c0 + 5);
      rd(1, 6'h00, 32'd5, "R6 fast load");
      rd(1, 6'h00, 32'd4, "R6 fast step each clock");
      rd(1, 6'h0C, 32'h0000_0001, "R4 slow bit not forced when unlocked");
      idle(10);
      rd(1, 6'h00, 32'd0, "R7 fast count holds zero");

      idle(5);
      note(pq0.size() == 0, "R7 all default-unit pulses seen", 32'(pq0.size()), 32'd0);
      note(pq1.size() == 0, "R7 all fast-unit pulses seen", 32'(pq1.size()), 32'd0);
      note(rd_q.size() == 0, "R2 all reads checked", 32'(rd_q.size()), 32'd0);
      summary();
      $finish;
   end
endmodule